// File: doc/BRIEF.md
# Flash Erase/Program Protection Guard

This block sits between the bus and the high-voltage controls of a 32 KB flash address space whose lower 4 KB are not populated, leaving the array at 0x1000 to 0x7FFF. It holds a 4-bit protect register. Each bit locks a range of addresses that ends at the top of the array. It also holds a small control register with program, erase and high-voltage enable bits.

When software writes a program or erase request, the block works out the span the operation covers from the presented operation address and size. If any address in that span is locked, the request bit is dropped and a one-cycle violation pulse is raised. High-voltage enable can only be set while a valid request is already held. A cancelled request therefore never reaches the array voltage.

Top module: `fbp_guard`

## Requirements
- R1: After reset the protect register reads 0x0F, the control register reads 0x00 and `viol_o` is 0.
- R2: The protect register sits at bus address 0x32. A write stores data bits 3:0. Reads at 0x32 return those bits in 3:0 and zero in 7:4. Writes to any other address leave it unchanged.
- R3: With only protect bit 3 set, the locked region is 0x4000 to 0x7FFF.
- R4: With only protect bit 2 set, the locked region is 0x2000 to 0x7FFF.
- R5: With protect bit 1 or bit 0 set, the locked region is 0x1000 to 0x7FFF.
- R6: With several protect bits set, the locked region is the union of their regions, so the lowest start wins.
- R7: With all protect bits clear, no request is ever cancelled.
- R8: `op_size_i` gives the span: 0 = the single byte at `op_addr_i`, 1 = the aligned 64-byte row holding it, 2 = the aligned 512-byte block holding it, 3 = the whole array. A request is cancelled if any address of the span is locked.
- R9: The control register sits at bus address 0x30: bit 0 program, bit 1 erase, bit 2 high-voltage enable, other bits read 0. A write that requests program or erase on a locked span stores both request bits as 0. It raises `viol_o` for exactly the following cycle.
- R10: A write sets high-voltage enable only if program or erase was already held before the write and stays set after it. Otherwise that bit stays 0, including after a cancellation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Bus write strobe |
| bus_addr_i | input | 8 | Bus register address |
| bus_wdata_i | input | 8 | Bus write data |
| bus_rdata_o | output | 8 | Read data for the addressed register |
| op_addr_i | input | 15 | Address of the pending operation |
| op_size_i | input | 2 | Span code of the pending operation |
| ctrl_o | output | 8 | Gated control register view |
| viol_o | output | 1 | One-cycle protection violation pulse |

## Verification
The bench builds the block with its default parameters. These are a 15-bit address space, four protect bits, a 0x1000 populated base, 64-byte rows and 512-byte blocks. With these values every region boundary (0x1000, 0x2000, 0x4000) can be probed one byte below and at the boundary. Row and block spans placed just under a boundary show that alignment keeps them open. Mass operations show that a set protect bit cancels them regardless of the address presented. The scoreboard tracks the held request bits across operations, so the high-voltage rule is tested both after a valid request and after a cancellation.

// File: rtl/fbp_pkg.sv
package fbp_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_ROW   = 2'd1,
    SZ_BLOCK = 2'd2,
    SZ_MASS  = 2'd3
  } op_size_e;

  localparam int unsigned CB_PGM  = 0;
  localparam int unsigned CB_ERS  = 1;
  localparam int unsigned CB_HVEN = 2;
endpackage

// File: rtl/fbp_span_end.sv
module fbp_span_end
  import fbp_pkg::*;
#(
  parameter int unsigned ADDR_W    = 15,
  parameter int unsigned ROW_BYTES = 64,
  parameter int unsigned BLK_BYTES = 512
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  output logic [ADDR_W-1:0] end_o
);
  localparam logic [ADDR_W-1:0] ROW_MASK = ADDR_W'(ROW_BYTES - 1);
  localparam logic [ADDR_W-1:0] BLK_MASK = ADDR_W'(BLK_BYTES - 1);

  // spans are aligned, so only the last address matters against a top-anchored region
  always_comb begin
    unique case (op_size_e'(size_i))
      SZ_BYTE:  end_o = addr_i;
      SZ_ROW:   end_o = addr_i | ROW_MASK;
      SZ_BLOCK: end_o = addr_i | BLK_MASK;
      default:  end_o = '1;
    endcase
  end
endmodule

// File: rtl/fbp_floor.sv
module fbp_floor #(
  parameter int unsigned ADDR_W   = 15,
  parameter int unsigned NPB      = 4,
  parameter int unsigned POP_BASE = 'h1000
) (
  input  logic [NPB-1:0]    bpr_i,
  output logic [ADDR_W-1:0] floor_o,
  output logic              any_o
);
  localparam logic [ADDR_W:0] SPACE = (ADDR_W+1)'(1) << ADDR_W;

  logic [ADDR_W-1:0] start_w [NPB];

  for (genvar g = 0; g < NPB; g++) begin : g_start
    if (g == 0) begin : g_pop
      assign start_w[g] = ADDR_W'(POP_BASE);
    end else begin : g_frac
      assign start_w[g] = ADDR_W'(SPACE >> (NPB - g));
    end
  end

  always_comb begin
    floor_o = '1;
    for (int k = 0; k < NPB; k++) begin
      if (bpr_i[k] && (start_w[k] < floor_o)) floor_o = start_w[k];
    end
  end

  assign any_o = |bpr_i;
endmodule

// File: rtl/fbp_ctrl_gate.sv
module fbp_ctrl_gate
  import fbp_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          hit_i,
  output logic [DW-1:0] ctrl_o,
  output logic          viol_o
);
  logic pgm_q, ers_q, hven_q, viol_q;
  logic pgm_d, ers_d, hven_d, req_w;

  assign req_w  = wdata_i[CB_PGM] | wdata_i[CB_ERS];
  assign pgm_d  = wdata_i[CB_PGM] & ~hit_i;
  assign ers_d  = wdata_i[CB_ERS] & ~hit_i;
  // HV only on top of a request already held and still held
  assign hven_d = wdata_i[CB_HVEN] & (pgm_q | ers_q) & (pgm_d | ers_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pgm_q  <= 1'b0;
      ers_q  <= 1'b0;
      hven_q <= 1'b0;
      viol_q <= 1'b0;
    end else begin
      viol_q <= we_i & req_w & hit_i;
      if (we_i) begin
        pgm_q  <= pgm_d;
        ers_q  <= ers_d;
        hven_q <= hven_d;
      end
    end
  end

  always_comb begin
    ctrl_o          = '0;
    ctrl_o[CB_PGM]  = pgm_q;
    ctrl_o[CB_ERS]  = ers_q;
    ctrl_o[CB_HVEN] = hven_q;
  end

  assign viol_o = viol_q;
endmodule

// File: rtl/fbp_guard.sv
module fbp_guard
  import fbp_pkg::*;
#(
  parameter int unsigned ADDR_W    = 15,
  parameter int unsigned BUS_AW    = 8,
  parameter int unsigned DW        = 8,
  parameter int unsigned NPB       = 4,
  parameter int unsigned POP_BASE  = 'h1000,
  parameter int unsigned ROW_BYTES = 64,
  parameter int unsigned BLK_BYTES = 512,
  parameter int unsigned BPR_ADDR  = 'h32,
  parameter int unsigned CTRL_ADDR = 'h30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  input  logic [ADDR_W-1:0] op_addr_i,
  input  logic [1:0]        op_size_i,
  output logic [DW-1:0]     ctrl_o,
  output logic              viol_o
);
  localparam logic [BUS_AW-1:0] A_BPR  = BUS_AW'(BPR_ADDR);
  localparam logic [BUS_AW-1:0] A_CTRL = BUS_AW'(CTRL_ADDR);

  logic [NPB-1:0]    bpr_q;
  logic [ADDR_W-1:0] end_w, floor_w;
  logic              any_w, hit_w, sel_bpr, sel_ctrl;

  assign sel_bpr  = bus_addr_i == A_BPR;
  assign sel_ctrl = bus_addr_i == A_CTRL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  bpr_q <= '1;
    else if (bus_we_i && sel_bpr) bpr_q <= bus_wdata_i[NPB-1:0];
  end

  fbp_span_end #(
    .ADDR_W(ADDR_W), .ROW_BYTES(ROW_BYTES), .BLK_BYTES(BLK_BYTES)
  ) u_span (
    .addr_i(op_addr_i), .size_i(op_size_i), .end_o(end_w)
  );

  fbp_floor #(
    .ADDR_W(ADDR_W), .NPB(NPB), .POP_BASE(POP_BASE)
  ) u_floor (
    .bpr_i(bpr_q), .floor_o(floor_w), .any_o(any_w)
  );

  assign hit_w = any_w & (end_w >= floor_w);

  fbp_ctrl_gate #(.DW(DW)) u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(bus_we_i & sel_ctrl),
    .wdata_i(bus_wdata_i), .hit_i(hit_w), .ctrl_o(ctrl_o), .viol_o(viol_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (sel_bpr)       bus_rdata_o[NPB-1:0] = bpr_q;
    else if (sel_ctrl) bus_rdata_o = ctrl_o;
  end
endmodule

// File: rtl/fbp_guard_chk.sv
module fbp_guard_chk #(
  parameter int unsigned ADDR_W    = 15,
  parameter int unsigned BUS_AW    = 8,
  parameter int unsigned DW        = 8,
  parameter int unsigned NPB       = 4,
  parameter int unsigned BPR_ADDR  = 'h32,
  parameter int unsigned CTRL_ADDR = 'h30
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_we_i,
  input logic [BUS_AW-1:0] bus_addr_i,
  input logic [DW-1:0]     bus_wdata_i,
  input logic [DW-1:0]     bus_rdata_o,
  input logic [ADDR_W-1:0] op_addr_i,
  input logic [1:0]        op_size_i,
  input logic [DW-1:0]     ctrl_o,
  input logic              viol_o,
  input logic [NPB-1:0]    bpr_i
);
  localparam logic [BUS_AW-1:0] A_BPR  = BUS_AW'(BPR_ADDR);
  localparam logic [BUS_AW-1:0] A_CTRL = BUS_AW'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] HALF   = ADDR_W'(1) << (ADDR_W - 1);

  p_hven_needs_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[2] |-> (ctrl_o[0] | ctrl_o[1]));

  p_hven_rise_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_o[2]) |-> $past(ctrl_o[0] | ctrl_o[1]));

  p_viol_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> $past(bus_we_i && bus_addr_i == A_CTRL));

  p_viol_drops_req_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> !(ctrl_o[0] | ctrl_o[1]));

  p_bpr_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_we_i && bus_addr_i == A_BPR) |=> $stable(bpr_i));

  p_rdata_upper_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == A_BPR) |-> (bus_rdata_o[DW-1:NPB] == '0));

  p_all_open_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bpr_i == '0 && bus_we_i && bus_addr_i == A_CTRL) |=> !viol_o);

  p_top_half_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bpr_i[NPB-1] && bus_we_i && bus_addr_i == A_CTRL && bus_wdata_i[0]
     && op_size_i == 2'd0 && op_addr_i >= HALF) |=> viol_o);
endmodule

bind fbp_guard fbp_guard_chk #(
  .ADDR_W(ADDR_W), .BUS_AW(BUS_AW), .DW(DW), .NPB(NPB),
  .BPR_ADDR(BPR_ADDR), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
  .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .op_addr_i(op_addr_i),
  .op_size_i(op_size_i), .ctrl_o(ctrl_o), .viol_o(viol_o), .bpr_i(bpr_q)
);

// File: tb/fbp_guard_tb.sv
module fbp_guard_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_we_i = 1'b0;
  logic [7:0]  bus_addr_i = 8'h00;
  logic [7:0]  bus_wdata_i = 8'h00;
  logic [7:0]  bus_rdata_o;
  logic [14:0] op_addr_i = '0;
  logic [1:0]  op_size_i = 2'd0;
  logic [7:0]  ctrl_o;
  logic        viol_o;

  int tests = 0;
  int fails = 0;

  typedef struct {
    logic [7:0] ctrl;
    logic       viol;
    string      tag;
  } exp_t;
  exp_t sbq[$];

  logic [3:0] m_bpr = 4'hF;
  logic [7:0] m_ctrl = 8'h00;

  fbp_guard u_dut (.*);

  always #5 clk_i = ~clk_i;

  function automatic void chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endfunction

  // monitor: compares registered results one cycle after each control write
  always @(negedge clk_i) begin
    if (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      chk({e.tag, " ctrl"}, 32'(ctrl_o), 32'(e.ctrl));
      chk({e.tag, " viol"}, 32'(viol_o), 32'(e.viol));
    end
  end

  function automatic logic locked(logic [3:0] b, logic [14:0] a, logic [1:0] s);
    logic [14:0] last;
    logic [15:0] flo;
    case (s)
      2'd0: last = a;
      2'd1: last = a | 15'h003F;
      2'd2: last = a | 15'h01FF;
      default: last = 15'h7FFF;
    endcase
    if (b[1] | b[0]) flo = 16'h1000;
    else if (b[2])   flo = 16'h2000;
    else if (b[3])   flo = 16'h4000;
    else             flo = 16'h8000;
    return {1'b0, last} >= flo;
  endfunction

  task automatic bus_wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk_i);
    bus_addr_i = a; bus_wdata_i = d; bus_we_i = 1'b1;
    @(posedge clk_i); #1;
    bus_we_i = 1'b0;
  endtask

  task automatic set_bpr(logic [3:0] b);
    bus_wr(8'h32, {4'hA, b});
    m_bpr = b;
  endtask

  task automatic rd_chk(string tag, logic [7:0] a, logic [7:0] exp);
    @(negedge clk_i);
    bus_addr_i = a; #1;
    chk(tag, 32'(bus_rdata_o), 32'(exp));
  endtask

  // driver: one control write, expected result pushed to the scoreboard
  task automatic op(string tag, logic [14:0] a, logic [1:0] s, logic [7:0] w);
    exp_t e;
    logic h, p, r, v;
    h = locked(m_bpr, a, s);
    p = w[0] & ~h;
    r = w[1] & ~h;
    v = (w[0] | w[1]) & h;
    e.ctrl = {5'b0, w[2] & (m_ctrl[0] | m_ctrl[1]) & (p | r), r, p};
    e.viol = v;
    e.tag  = tag;
    @(negedge clk_i);
    op_addr_i = a; op_size_i = s;
    bus_addr_i = 8'h30; bus_wdata_i = w; bus_we_i = 1'b1;
    @(posedge clk_i); #1;
    bus_we_i = 1'b0;
    sbq.push_back(e);
    m_ctrl = e.ctrl;
    @(negedge clk_i);
    @(negedge clk_i); #1;
    chk({tag, " pulse end R9"}, 32'(viol_o), 32'(0));
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    // R1
    rd_chk("R1 bpr", 8'h32, 8'h0F);
    rd_chk("R1 ctrl", 8'h30, 8'h00);
    chk("R1 viol", 32'(viol_o), 32'(0));
    op("R1 reset locks 0x1000", 15'h1000, 2'd0, 8'h01);
    // R2
    bus_wr(8'h32, 8'hF5); m_bpr = 4'h5;
    rd_chk("R2 upper zero", 8'h32, 8'h05);
    bus_wr(8'h31, 8'h00);
    rd_chk("R2 other addr ignored", 8'h32, 8'h05);
    // R7
    set_bpr(4'h0);
    rd_chk("R2 cleared", 8'h32, 8'h00);
    op("R7 erase top", 15'h7FFF, 2'd0, 8'h02);
    op("R10 hven on held erase", 15'h7FFF, 2'd0, 8'h06);
    rd_chk("R10 ctrl read", 8'h30, 8'h06);
    op("R7 mass open", 15'h0000, 2'd3, 8'h02);
    op("R9 clear", 15'h0000, 2'd0, 8'h00);
    // R3
    set_bpr(4'h8);
    op("R3 below", 15'h3FFF, 2'd0, 8'h01);
    op("R3 at", 15'h4000, 2'd0, 8'h01);
    op("R10 hven after cancel", 15'h3FFF, 2'd0, 8'h04);
    op("R8 row under", 15'h3FC5, 2'd1, 8'h01);
    op("R8 block under", 15'h3E10, 2'd2, 8'h02);
    op("R8 block in", 15'h4010, 2'd2, 8'h02);
    op("R8 mass", 15'h0000, 2'd3, 8'h02);
    // R4
    set_bpr(4'h4);
    op("R4 below", 15'h1FFF, 2'd0, 8'h01);
    op("R4 at", 15'h2000, 2'd0, 8'h01);
    op("R8 row in", 15'h2001, 2'd1, 8'h02);
    // R5
    set_bpr(4'h2);
    op("R5 b1 below", 15'h0FFF, 2'd0, 8'h01);
    op("R5 b1 at", 15'h1000, 2'd0, 8'h01);
    set_bpr(4'h1);
    op("R5 b0 below", 15'h0FFF, 2'd0, 8'h02);
    op("R5 b0 at", 15'h1000, 2'd0, 8'h02);
    // R6
    set_bpr(4'hC);
    op("R6 below", 15'h1FFF, 2'd0, 8'h01);
    op("R6 at", 15'h2000, 2'd0, 8'h01);
    set_bpr(4'hA);
    op("R6 low wins", 15'h1000, 2'd0, 8'h02);
    // R10
    set_bpr(4'h0);
    op("R10 hven with new req", 15'h5000, 2'd0, 8'h05);
    op("R10 hven on held pgm", 15'h5000, 2'd0, 8'h05);
    op("R10 hven alone drops", 15'h5000, 2'd0, 8'h04);
    repeat (2) @(negedge clk_i);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule